// File: doc/BRIEF.md
# NVRAM Region Checksum Engine

This block computes a 16-bit checksum over a contiguous run of bytes held in a small byte-wide memory. A client gives a first address and a byte count and pulses a start input. The engine then reads the bytes one per cycle through a synchronous read port. It pairs consecutive bytes into big-endian 16-bit words and folds each word into a running checksum with a nibble-based XOR-and-shift update.

When the last word has been folded in, the engine pulses `done` for one cycle. The checksum stays on `result` until the next accepted start. A region with an odd length ends with a half word, which carries the final byte in its upper half and zero in its lower half. A typical use checks 248 bytes from address 0. Software then stores the value elsewhere, but that store is not part of this block.

Top module: `nvcsum_engine`

## Requirements
- R1: After reset `done` is 0, `mem_rd_en` is 0 and `result` is 0xFFFF.
- R2: Each word is built from two successive bytes: the byte at the lower address goes in bits 15:8 and the next byte goes in bits 7:0.
- R3: For each word w, with old checksum c, let p = c XOR w, a = p[3:0] and b = p[7:4] XOR a. The new checksum is (c >> 8) XOR (a << 3) XOR (a << 8) XOR b XOR (b << 7) XOR (b << 12), truncated to 16 bits.
- R4: Each accepted start reloads the checksum with 0xFFFF before any word is folded in.
- R5: When the byte count is odd, the final byte is folded as a word with that byte in bits 15:8 and 0x00 in bits 7:0.
- R6: A job with count N issues exactly N reads, one per cycle with no gaps. The first read is at `start_addr`, and each later address is one higher, wrapping modulo 2^AW.
- R7: `done` is high for exactly one cycle per job. `result` holds the final checksum from that cycle until the next accepted start.
- R8: A start is accepted only when the engine is idle. A start raised at any time from an accepted start up to and including the cycle of its `done` has no effect on the reads or on the result.
- R9: A job with count 0 issues no reads and finishes with `done` and a result of 0xFFFF.
- R10: A 248-byte region from address 0 yields the checksum that the equation of R3 gives over those bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a job |
| start_addr | input | AW | First byte address of the region |
| byte_count | input | CW | Number of bytes in the region |
| mem_rd_en | output | 1 | Read strobe to the byte memory |
| mem_addr | output | AW | Read address to the byte memory |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | One-cycle pulse when the checksum is final |
| result | output | 16 | Checksum value |

## Verification
Two things can land in the same cycle: the completion pulse of a job and a fresh start request from the client. The bench raises start in the very cycle that `done` is high, and also partway through the reads of a long job. It then checks that no more reads appear, that no second `done` follows, and that `result` keeps the checksum of the first job. An odd-length job, in which the final byte is both the first half of a word and the end of the job, is also checked against fixed hand-computed values.

// File: rtl/nvcsum_pkg.sv
package nvcsum_pkg;
  localparam int CSUM_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [CSUM_W-1:0] CSUM_SEED = 16'hFFFF;

  // One word folded into the running checksum.
  function automatic logic [CSUM_W-1:0] csum_fold(input logic [CSUM_W-1:0] acc,
                                                   input logic [CSUM_W-1:0] word);
    logic [CSUM_W-1:0] mix;
    logic [3:0]        lo_nib;
    logic [3:0]        hi_nib;
    mix    = acc ^ word;
    lo_nib = mix[3:0];
    hi_nib = mix[7:4] ^ lo_nib;
    csum_fold = {8'h00, acc[15:8]}
              ^ {9'b0, lo_nib, 3'b0}
              ^ {4'b0, lo_nib, 8'b0}
              ^ {12'b0, hi_nib}
              ^ {5'b0, hi_nib, 7'b0}
              ^ {hi_nib, 12'b0};
  endfunction
endpackage

// File: rtl/nvcsum_addr_gen.sv
module nvcsum_addr_gen #(
  parameter int AW = 8,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_last,
  output logic          empty_evt
);
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] left_q;
  logic          active_q;
  logic          empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
      empty_q  <= 1'b0;
    end else begin
      empty_q <= 1'b0;
      if (launch) begin
        ptr_q    <= base_addr;
        left_q   <= len;
        active_q <= (len != '0);
        empty_q  <= (len == '0);
      end else if (active_q) begin
        ptr_q  <= ptr_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) active_q <= 1'b0;
      end
    end
  end

  assign rd_en     = active_q;
  assign rd_addr   = ptr_q;
  assign rd_last   = active_q && (left_q == CW'(1));
  assign empty_evt = empty_q;

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_last) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));
  // R8
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !rd_en);
endmodule

// File: rtl/nvcsum_word_pack.sv
module nvcsum_word_pack
  import nvcsum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_vld,
  input  logic              byte_last,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_vld,
  output logic              word_last,
  output logic [CSUM_W-1:0] word
);
  logic              have_hi_q;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_hi_q <= 1'b0;
      hi_q      <= '0;
      word_vld  <= 1'b0;
      word_last <= 1'b0;
      word      <= '0;
    end else begin
      word_vld  <= 1'b0;
      word_last <= 1'b0;
      if (clear) begin
        have_hi_q <= 1'b0;
      end else if (byte_vld) begin
        if (have_hi_q) begin
          word      <= {hi_q, byte_in};
          word_vld  <= 1'b1;
          word_last <= byte_last;
          have_hi_q <= 1'b0;
        end else if (byte_last) begin
          word      <= {byte_in, 8'h00};
          word_vld  <= 1'b1;
          word_last <= 1'b1;
        end else begin
          hi_q      <= byte_in;
          have_hi_q <= 1'b1;
        end
      end
    end
  end

  // R5
  odd_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_last && !have_hi_q) |=> (word_vld && word[7:0] == 8'h00));
endmodule

// File: rtl/nvcsum_accum.sv
module nvcsum_accum
  import nvcsum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              word_vld,
  input  logic              word_last,
  input  logic [CSUM_W-1:0] word,
  input  logic              empty_evt,
  output logic [CSUM_W-1:0] acc,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= CSUM_SEED;
      done <= 1'b0;
    end else begin
      done <= (word_vld && word_last) || empty_evt;
      if (seed)          acc <= CSUM_SEED;
      else if (word_vld) acc <= csum_fold(acc, word);
    end
  end

  // R4
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (acc == 16'hFFFF));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/nvcsum_engine.sv
module nvcsum_engine
  import nvcsum_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [CW-1:0]     byte_count,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [BYTE_W-1:0] mem_rd_data,
  output logic              done,
  output logic [CSUM_W-1:0] result
);
  logic              busy_q;
  logic              accept;
  logic              rd_last;
  logic              empty_evt;
  logic              rvld_q;
  logic              rlast_q;
  logic              word_vld;
  logic              word_last;
  logic [CSUM_W-1:0] word;

  assign accept = start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rvld_q  <= 1'b0;
      rlast_q <= 1'b0;
    end else begin
      if (accept)    busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      rvld_q  <= mem_rd_en;
      rlast_q <= rd_last;
    end
  end

  nvcsum_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst_n(rst_n), .launch(accept), .base_addr(start_addr),
    .len(byte_count), .rd_en(mem_rd_en), .rd_addr(mem_addr),
    .rd_last(rd_last), .empty_evt(empty_evt)
  );

  nvcsum_word_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clear(accept), .byte_vld(rvld_q),
    .byte_last(rlast_q), .byte_in(mem_rd_data), .word_vld(word_vld),
    .word_last(word_last), .word(word)
  );

  nvcsum_accum u_acc (
    .clk(clk), .rst_n(rst_n), .seed(accept), .word_vld(word_vld),
    .word_last(word_last), .word(word), .empty_evt(empty_evt),
    .acc(result), .done(done)
  );

  // R6
  read_in_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy_q);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(result));
  // R8
  done_in_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_q);
endmodule

// File: tb/sim_nvcsum_engine.sv
module sim_nvcsum_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rd_data = '0;
  logic          done;
  logic [15:0]   result;

  logic [7:0]    mem [256];
  logic [15:0]   exp_q[$];
  string         tag_q[$];
  logic [15:0]   popped;
  string         ptag;
  logic [AW-1:0] exp_addr = '0;
  int            rd_count = 0;
  int            nchk = 0;
  int            nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvcsum_engine #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .done(done), .result(result)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference update, restated as constant multiplies of non-overlapping fields.
  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] p, a, b;
    p = c ^ w;
    a = {12'b0, p[3:0]};
    b = {12'b0, p[7:4] ^ p[3:0]};
    return (c >> 8) ^ 16'(a * 16'h0108) ^ 16'(b * 16'h1081);
  endfunction

  function automatic logic [15:0] ref_csum(input int a, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i += 2) begin
      logic [7:0] hi = mem[8'(a + i)];
      logic [7:0] lo = (i + 1 < n) ? mem[8'(a + i + 1)] : 8'h00;
      c = ref_step(c, {hi, lo});
    end
    return c;
  endfunction

  // Monitor: address stream and scoreboard pop on completion.
  always @(negedge clk) begin
    if (rst_n && mem_rd_en) begin
      chk(mem_addr == exp_addr, "R6 read address", mem_addr, exp_addr);
      exp_addr = exp_addr + 1'b1;
      rd_count = rd_count + 1;
    end
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        popped = exp_q.pop_front();
        ptag   = tag_q.pop_front();
        chk(result == popped, ptag, result, popped);
      end
    end
  end

  task automatic launch(input int a, input int n, input logic [15:0] expv, input string tag);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    exp_addr = AW'(a);
    rd_count = 0;
    @(negedge clk);
    start = 1'b1; start_addr = AW'(a); byte_count = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_job(input int a, input int n, input logic [15:0] expv, input string tag);
    launch(a, n, expv, tag);
    wait_done();
    chk(rd_count == n, "R6 read count", rd_count, n);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(result == expv, "R7 result held", result, expv);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29 + 7);
    mem[8'h80] = 8'h12;
    mem[8'h81] = 8'h34;
    mem[8'h90] = 8'hAB;

    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(mem_rd_en == 1'b0, "R1 rd_en", mem_rd_en, 0);
    chk(result == 16'hFFFF, "R1 result", result, 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: bytes 12,34 -> word 0x1234 -> 0x7820 by hand
    run_job(8'h80, 2, 16'h7820, "R2 R3 fixed pair");
    // R5: single byte AB -> word 0xAB00 -> 0x0F87 by hand
    run_job(8'h90, 1, 16'h0F87, "R5 single odd byte");
    run_job(8'h20, 3, ref_csum(8'h20, 3), "R5 odd count 3");
    run_job(8'h05, 8, ref_csum(8'h05, 8), "R3 even count 8");
    // R4: back-to-back jobs each start from the seed
    run_job(8'h05, 8, ref_csum(8'h05, 8), "R4 reseed");
    run_job(254, 5, ref_csum(254, 5), "R6 address wrap");
    run_job(8'h33, 0, 16'hFFFF, "R9 empty region");
    run_job(0, 248, ref_csum(0, 248), "R10 typical region");

    // R8: start during reads and in the done cycle is ignored
    launch(8'h10, 20, ref_csum(8'h10, 20), "R8 job with stray starts");
    repeat (5) @(negedge clk);
    start = 1'b1; start_addr = 8'h40; byte_count = 3;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    start = 1'b1; start_addr = 8'h50; byte_count = 4;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk(rd_count == 20, "R8 no extra reads", rd_count, 20);
    chk(result == ref_csum(8'h10, 20), "R8 result kept", result, ref_csum(8'h10, 20));
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule